// File: doc/BRIEF.md
# Open Bus Data Latch with Per-Line Decay

This block stands beside a shared 8-bit data bus on which a read may find no device answering on some or all of the lines. It remembers the last level seen on every line and fills undriven lines of a read with that remembered level. The resolved read data is combinational. Driven lines pass straight from the bus, undriven lines come from the kept state or from a forced level. The kept state is updated on the clock edge that ends the bus cycle.

Each line has its own small state machine with two states. `CELL_DECAYED` holds a kept value of 0. `CELL_HELD` holds a live value and an age counted in frame ticks. The transitions are:
- load: `CELL_DECAYED`→`CELL_HELD` when the line is driven.
- refresh: `CELL_HELD`→`CELL_HELD` when the line is driven. The new level is stored and the age is cleared.
- age: `CELL_HELD`→`CELL_HELD` on a frame tick below the limit.
- expire: `CELL_HELD`→`CELL_DECAYED` on the frame tick that reaches the limit.
- stay: `CELL_DECAYED`→`CELL_DECAYED` otherwise.

A write cycle drives every line. A read cycle drives only the lines set in its drive mask. A two-bit mode input selects one of four behaviours: normal decay, hold forever, force undriven lines low, or force undriven lines high.

Top module: `obus_latch`

## Requirements
- R1: After reset every kept line reads 0 until it is driven.
- R2: A write cycle (`cyc_stb`=1, `cyc_wr`=1) returns `bus_data` on all lines whatever `bus_drv` holds, and stores all 8 lines.
- R3: A read cycle (`cyc_stb`=1, `cyc_wr`=0) returns `bus_data` on lines whose `bus_drv` bit is 1 and the kept level on the other lines.
- R4: A read cycle stores only the lines whose `bus_drv` bit is 1; the kept level of every other line is unchanged.
- R5: With `cyc_stb`=0, `bus_data` and `bus_drv` are ignored and `rd_data` equals the kept state (in mode 00).
- R6: In mode 00 a line's kept level becomes 0 on the TIMEOUT_TICKS-th `frame_tick` after it was last driven, and is unchanged before that tick.
- R7: Driving a line restarts only that line's age; the ages of the other lines continue.
- R8: When a line is driven in the same cycle as a `frame_tick`, the drive wins and the line's age starts from 0.
- R9: In mode 01 (hold), frame ticks do not age or decay any line. On return to mode 00, ageing resumes from the frozen age.
- R10: In modes 10 and 11, undriven lines read 0 and 1 respectively. Kept state and ageing continue as in mode 00 and can be read back after returning to mode 00.
- R11: A decayed line stays 0 through further frame ticks until it is driven again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Bus cycle active this clock |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_data | input | 8 | Data levels present on driven lines |
| bus_drv | input | 8 | Per-line drive enable for read cycles |
| frame_tick | input | 1 | One-cycle pulse per video frame |
| mode_sel | input | 2 | 00 decay, 01 hold, 10 force low, 11 force high |
| rd_data | output | 8 | Resolved read data |

## Verification
The hardest situation to reach is a byte whose lines have different ages, so that one frame tick expires some lines and leaves others alive. The stimulus writes a full byte, spends one tick, refreshes only the upper nibble with a masked read, and then checks that the next tick clears only the lower nibble. Two further sequences are checked the same way. In the first, a drive and a tick land in the same cycle. In the second, ageing is frozen in hold mode and then resumed, and the exact tick on which the lines expire is checked.

// File: rtl/obus_pkg.sv
package obus_pkg;

    typedef enum logic [1:0] {
        MODE_DECAY  = 2'b00,
        MODE_HOLD   = 2'b01,
        MODE_FORCE0 = 2'b10,
        MODE_FORCE1 = 2'b11
    } obus_mode_e;

    typedef enum logic {
        CELL_DECAYED = 1'b0,
        CELL_HELD    = 1'b1
    } cell_state_e;

endpackage

// File: rtl/obus_drive_decode.sv
module obus_drive_decode #(
    parameter int unsigned W = 8
) (
    input  logic         cyc_stb,
    input  logic         cyc_wr,
    input  logic [W-1:0] bus_drv,
    output logic [W-1:0] drv_eff
);

    // Writes drive every line; reads drive only masked lines; idle drives none.
    always_comb begin
        if (!cyc_stb) begin
            drv_eff = '0;
        end else if (cyc_wr) begin
            drv_eff = '1;
        end else begin
            drv_eff = bus_drv;
        end
    end

endmodule

// File: rtl/obus_bit_cell.sv
module obus_bit_cell
    import obus_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    input  logic tick,
    input  logic hold,
    output logic kept_o
);

    localparam int unsigned AGE_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(TIMEOUT_TICKS - 1);

    cell_state_e      state_q, state_d;
    logic [AGE_W-1:0] age_q, age_d;
    logic             val_q, val_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CELL_DECAYED;
            age_q   <= '0;
            val_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
            val_q   <= val_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        val_d   = val_q;
        unique case (state_q)
            CELL_DECAYED: begin
                if (load) begin
                    state_d = CELL_HELD;
                    val_d   = din;
                    age_d   = '0;
                end
            end
            CELL_HELD: begin
                if (load) begin
                    val_d = din;
                    age_d = '0;
                end else if (tick && !hold) begin
                    if (age_q == AGE_LAST) begin
                        state_d = CELL_DECAYED;
                        val_d   = 1'b0;
                        age_d   = '0;
                    end else begin
                        age_d = age_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            CELL_DECAYED: kept_o = 1'b0;
            CELL_HELD:    kept_o = val_q;
        endcase
    end

endmodule

// File: rtl/obus_resolve.sv
module obus_resolve
    import obus_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] drv_eff,
    input  logic [W-1:0] bus_data,
    input  logic [W-1:0] kept,
    input  obus_mode_e   mode,
    output logic [W-1:0] rd_data
);

    logic [W-1:0] fill;

    always_comb begin
        unique case (mode)
            MODE_FORCE0: fill = '0;
            MODE_FORCE1: fill = '1;
            MODE_DECAY,
            MODE_HOLD:   fill = kept;
        endcase
        rd_data = (drv_eff & bus_data) | (~drv_eff & fill);
    end

endmodule

// File: rtl/obus_latch.sv
module obus_latch
    import obus_pkg::*;
#(
    parameter int unsigned W             = 8,
    parameter int unsigned TIMEOUT_TICKS = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cyc_stb,
    input  logic         cyc_wr,
    input  logic [W-1:0] bus_data,
    input  logic [W-1:0] bus_drv,
    input  logic         frame_tick,
    input  logic [1:0]   mode_sel,
    output logic [W-1:0] rd_data
);

    obus_mode_e   mode;
    logic [W-1:0] drv_eff;
    logic [W-1:0] kept_q;
    logic         hold;

    assign mode = obus_mode_e'(mode_sel);
    assign hold = (mode == MODE_HOLD);

    obus_drive_decode #(.W(W)) u_dec (
        .cyc_stb (cyc_stb),
        .cyc_wr  (cyc_wr),
        .bus_drv (bus_drv),
        .drv_eff (drv_eff)
    );

    for (genvar i = 0; i < W; i++) begin : g_line
        obus_bit_cell #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (drv_eff[i]),
            .din    (bus_data[i]),
            .tick   (frame_tick),
            .hold   (hold),
            .kept_o (kept_q[i])
        );
    end

    obus_resolve #(.W(W)) u_res (
        .drv_eff  (drv_eff),
        .bus_data (bus_data),
        .kept     (kept_q),
        .mode     (mode),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/obus_latch_chk.sv
module obus_latch_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cyc_stb,
    input logic         cyc_wr,
    input logic [W-1:0] bus_data,
    input logic [W-1:0] bus_drv,
    input logic         frame_tick,
    input logic [1:0]   mode_sel,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] kept
);

    // R2: a write returns the bus on every line
    a_r2_write_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && cyc_wr) |-> (rd_data == bus_data));

    // R3: masked lines of a read come from the bus
    a_r3_driven_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cyc_wr) |-> (((rd_data ^ bus_data) & bus_drv) == '0));

    // R4: unmasked lines keep their level across a read without a tick
    a_r4_undriven_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cyc_wr && !frame_tick) |=>
            (((kept ^ $past(kept)) & ~$past(bus_drv)) == '0));

    // R6: without a drive, a kept line can only fall, never rise
    a_r6_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_stb |=> ((kept & ~$past(kept)) == '0));

    // R9: hold mode freezes the kept state while the bus is idle
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && mode_sel == 2'b01) |=> $stable(kept));

    // R10: force-high mode reads all ones on an idle bus
    a_r10_force_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && mode_sel == 2'b11) |-> (rd_data == '1));

endmodule

bind obus_latch obus_latch_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_stb    (cyc_stb),
    .cyc_wr     (cyc_wr),
    .bus_data   (bus_data),
    .bus_drv    (bus_drv),
    .frame_tick (frame_tick),
    .mode_sel   (mode_sel),
    .rd_data    (rd_data),
    .kept       (kept_q)
);

// File: tb/sim_obus_latch.sv
module sim_obus_latch;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cyc_stb, cyc_wr, frame_tick;
    logic [7:0] bus_data, bus_drv, rd_data;
    logic [1:0] mode_sel;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    obus_latch u0 (
        .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .cyc_wr(cyc_wr),
        .bus_data(bus_data), .bus_drv(bus_drv), .frame_tick(frame_tick),
        .mode_sel(mode_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One clock of bus activity; result sampled mid-cycle before the edge.
    task automatic cyc(input logic stb, input logic wr, input logic [7:0] d,
                       input logic [7:0] m, input logic t, output logic [7:0] r);
        @(negedge clk);
        cyc_stb = stb; cyc_wr = wr; bus_data = d; bus_drv = m; frame_tick = t;
        #5 r = rd_data;
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        cyc_stb = 0; frame_tick = 0;
    endtask

    task automatic t_reset;
        logic [7:0] r;
        cyc(0, 0, 8'hFF, 8'hFF, 0, r); check("R1 idle after reset", r, 8'h00);
        cyc(1, 0, 8'hFF, 8'h00, 0, r); check("R1 undriven read after reset", r, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] r;
        cyc(1, 1, 8'hA5, 8'h00, 0, r); check("R2 write passes all lines", r, 8'hA5);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R2 write stored", r, 8'hA5);
        cyc(1, 0, 8'h3C, 8'h0F, 0, r); check("R3 masked read merge", r, 8'hAC);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R4 only masked lines stored", r, 8'hAC);
        cyc(0, 1, 8'hFF, 8'hFF, 0, r); check("R5 idle ignores bus", r, 8'hAC);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R5 idle stores nothing", r, 8'hAC);
    endtask

    task automatic t_decay;
        logic [7:0] r;
        cyc(1, 1, 8'hFF, 8'h00, 0, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R6 alive after one tick", r, 8'hFF);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R6 decayed on second tick", r, 8'h00);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(1, 0, 8'hFF, 8'h00, 0, r); check("R11 stays decayed", r, 8'h00);
    endtask

    task automatic t_refresh;
        logic [7:0] r;
        cyc(1, 1, 8'hFF, 8'h00, 0, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(1, 0, 8'hF0, 8'hF0, 0, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R7 only older nibble expires", r, 8'hF0);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R7 refreshed nibble expires later", r, 8'h00);
    endtask

    task automatic t_same_cycle;
        logic [7:0] r;
        cyc(1, 1, 8'h5A, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R8 drive beats tick", r, 8'h5A);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R8 expiry counted from drive", r, 8'h00);
    endtask

    task automatic t_hold;
        logic [7:0] r;
        cyc(1, 1, 8'h77, 8'h00, 0, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        set_mode(2'b01);
        for (int i = 0; i < 5; i++) cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R9 hold keeps value", r, 8'h77);
        set_mode(2'b00);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R9 value after leaving hold", r, 8'h77);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R9 ageing resumes from frozen age", r, 8'h00);
    endtask

    task automatic t_force;
        logic [7:0] r;
        cyc(1, 1, 8'h81, 8'h00, 0, r);
        set_mode(2'b10);
        cyc(1, 0, 8'h06, 8'h0F, 0, r); check("R10 force low", r, 8'h06);
        set_mode(2'b11);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R10 force high idle", r, 8'hFF);
        cyc(1, 0, 8'h06, 8'h0F, 0, r); check("R10 force high masked", r, 8'hF6);
        set_mode(2'b00);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R10 kept state intact", r, 8'h86);
        set_mode(2'b11);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        cyc(0, 0, 8'h00, 8'h00, 1, r);
        set_mode(2'b00);
        cyc(0, 0, 8'h00, 8'h00, 0, r); check("R10 ageing runs while forced", r, 8'h00);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cyc_stb = 0; cyc_wr = 0; bus_data = 0; bus_drv = 0;
        frame_tick = 0; mode_sel = 2'b00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        t_reset();
        t_write_read();
        t_decay();
        t_refresh();
        t_same_cycle();
        t_hold();
        t_force();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule